// File: doc/BRIEF.md
# Flash Write Qualifier and Sector Protection

This block sits between the bus-side control pins of a flash device and its command state machine. It decides when a bus write cycle counts as genuine, and for each accepted cycle whether the addressed sector may be programmed or erased. Only one combination of the control pins qualifies a write: chip select asserted, write strobe asserted and output enable deasserted. That combination must also hold for a configurable number of clock cycles before the block accepts it. A qualified cycle produces a single-cycle clean strobe, together with a flag that says whether the sector is writable.

Four independent sources can deny a write. A per-sector lock register is set and cleared by lock and unlock commands. A write-protect pin guards the first and last sectors. A program-voltage pin guards every sector. A low-supply flag blocks all write activity and also holds the command logic in read-array mode.

Top module: `flash_wr_guard`

## Requirements
- R1: A write qualifies only in a cycle where `ce_n`=0, `we_n`=0 and `oe_n`=1. `oe_n`=0, `ce_n`=1 or `we_n`=1 each blocks qualification.
- R2: `wr_strobe` pulses high for exactly one cycle, one cycle after the MIN_PULSE-th consecutive clock edge at which the write qualifies. A run shorter than MIN_PULSE gives no strobe. A longer run gives only one strobe.
- R3: When `wp_n`=0 at the qualifying edge, sector 0 and sector NUM_SECTORS-1 report `sector_wr_ok`=0.
- R4: When `vpp_hi`=0 at the qualifying edge, every sector reports `sector_wr_ok`=0.
- R5: A `lock_req` pulse sets the lock of sector `lock_sector`, and an `unlock_req` pulse clears it. A locked sector reports `sector_wr_ok`=0. If both requests arrive in the same cycle, the lock wins. A change takes effect for qualifying edges after the edge that applies it.
- R6: While `supply_low`=1, no strobe is produced, the qualification count restarts, and lock and unlock requests are ignored. `force_read` follows `supply_low` one cycle later.
- R7: Once `supply_low` returns to 0, writes qualify again. This needs a fresh run of MIN_PULSE qualifying edges.
- R8: On reset, all sectors are unlocked and the filter is idle. `wr_strobe`, `sector_wr_ok` and `force_read` are all 0.
- R9: `sector_wr_ok` is high only together with `wr_strobe`. It reflects `sector_addr` at the qualifying edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce_n | input | 1 | Chip select, active low |
| we_n | input | 1 | Write strobe pin, active low |
| oe_n | input | 1 | Output enable, active low |
| wp_n | input | 1 | Protects the outermost sectors when low |
| vpp_hi | input | 1 | Program voltage present; low protects all sectors |
| supply_low | input | 1 | Supply below write threshold |
| sector_addr | input | SEC_W | Sector addressed by the write |
| lock_req | input | 1 | Lock the sector given by lock_sector |
| unlock_req | input | 1 | Unlock the sector given by lock_sector |
| lock_sector | input | SEC_W | Target sector of a lock command |
| wr_strobe | output | 1 | One-cycle accepted write pulse |
| sector_wr_ok | output | 1 | Addressed sector may be programmed or erased |
| force_read | output | 1 | Command logic held in read-array mode |

## Verification
All three outputs are registered. A qualifying run that starts at edge k raises `wr_strobe` and `sector_wr_ok` in the cycle after edge k+MIN_PULSE-1. `force_read` follows `supply_low` one cycle later, and a lock command affects only qualifying edges after the edge that applied it. The bench's reference model advances at every rising edge using those same delays. The bench compares all three outputs at every falling edge, and also counts strobes per pulse to check the single-strobe and short-pulse cases.

// File: rtl/flash_wr_guard.sv
module flash_wr_guard #(
  parameter int NUM_SECTORS = 16,
  parameter int MIN_PULSE   = 3,
  localparam int SEC_W = (NUM_SECTORS > 1) ? $clog2(NUM_SECTORS) : 1,
  localparam int CNT_W = $clog2(MIN_PULSE + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ce_n,
  input  logic             we_n,
  input  logic             oe_n,
  input  logic             wp_n,
  input  logic             vpp_hi,
  input  logic             supply_low,
  input  logic [SEC_W-1:0] sector_addr,
  input  logic             lock_req,
  input  logic             unlock_req,
  input  logic [SEC_W-1:0] lock_sector,
  output logic             wr_strobe,
  output logic             sector_wr_ok,
  output logic             force_read
);

  logic [CNT_W-1:0]       run_cnt;
  logic [NUM_SECTORS-1:0] lock_bits;

  wire qual      = !ce_n && !we_n && oe_n;
  wire fire      = qual && !supply_low && (run_cnt == CNT_W'(MIN_PULSE - 1));
  wire addr_in   = {1'b0, sector_addr} < (SEC_W+1)'(NUM_SECTORS);
  wire lock_in   = {1'b0, lock_sector} < (SEC_W+1)'(NUM_SECTORS);
  wire outer     = (sector_addr == '0) || (sector_addr == SEC_W'(NUM_SECTORS - 1));
  wire permitted = addr_in && !lock_bits[sector_addr] && vpp_hi && !(!wp_n && outer);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_cnt <= '0;
    end else if (!qual || supply_low) begin
      run_cnt <= '0;
    end else if (run_cnt != CNT_W'(MIN_PULSE)) begin
      run_cnt <= run_cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_strobe    <= 1'b0;
      sector_wr_ok <= 1'b0;
      force_read   <= 1'b0;
    end else begin
      wr_strobe    <= fire;
      sector_wr_ok <= fire && permitted;
      force_read   <= supply_low;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lock_bits <= '0;
    end else if (!supply_low && lock_in) begin
      if (lock_req)        lock_bits[lock_sector] <= 1'b1;
      else if (unlock_req) lock_bits[lock_sector] <= 1'b0;
    end
  end

  assert_strobe_qual_R1: assert property (@(posedge clk) disable iff (!rst_n)
    wr_strobe |-> $past(!ce_n && !we_n && oe_n));

  assert_single_strobe_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_strobe |=> !wr_strobe);

  assert_outer_guard_R3: assert property (@(posedge clk) disable iff (!rst_n)
    sector_wr_ok |-> !(!$past(wp_n) &&
      ($past(sector_addr) == '0 || $past(sector_addr) == SEC_W'(NUM_SECTORS - 1))));

  assert_vpp_guard_R4: assert property (@(posedge clk) disable iff (!rst_n)
    sector_wr_ok |-> $past(vpp_hi));

  assert_supply_block_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_strobe |-> !$past(supply_low));

  assert_force_read_R6: assert property (@(posedge clk) disable iff (!rst_n)
    supply_low |=> force_read);

  assert_ok_with_strobe_R9: assert property (@(posedge clk) disable iff (!rst_n)
    sector_wr_ok |-> wr_strobe);

endmodule

// File: tb/flash_wr_guard_tb.sv
module flash_wr_guard_tb;
  localparam int NS = 16;
  localparam int MP = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b1, wp_n = 1'b1, vpp_hi = 1'b1, supply_low = 1'b0;
  logic [3:0] sector_addr = '0, lock_sector = '0;
  logic lock_req = 1'b0, unlock_req = 1'b0;
  logic wr_strobe, sector_wr_ok, force_read;

  int checks = 0, failures = 0, strobes = 0, oks = 0;
  int run = 0;
  bit lockq [NS];
  bit e_strobe = 0, e_ok = 0, e_force = 0;

  always #5 clk = ~clk;

  flash_wr_guard #(.NUM_SECTORS(NS), .MIN_PULSE(MP)) u_dut (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
    .wp_n(wp_n), .vpp_hi(vpp_hi), .supply_low(supply_low),
    .sector_addr(sector_addr), .lock_req(lock_req), .unlock_req(unlock_req),
    .lock_sector(lock_sector), .wr_strobe(wr_strobe),
    .sector_wr_ok(sector_wr_ok), .force_read(force_read));

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run = 0; e_strobe = 0; e_ok = 0; e_force = 0;
      foreach (lockq[i]) lockq[i] = 0;
    end else begin
      bit q, ns, nk;
      q = !ce_n && !we_n && oe_n;
      ns = 0; nk = 0;
      if (q && !supply_low) begin
        run++;
        if (run == MP) begin
          ns = 1;
          nk = !lockq[sector_addr] && vpp_hi &&
               !(!wp_n && (sector_addr == 0 || sector_addr == NS-1));
        end
      end else run = 0;
      if (!supply_low) begin
        if (lock_req) lockq[lock_sector] = 1;
        else if (unlock_req) lockq[lock_sector] = 0;
      end
      e_strobe = ns; e_ok = nk; e_force = supply_low;
    end
  end

  always @(negedge clk) if (rst_n) begin
    check(wr_strobe == e_strobe, "R2 wr_strobe", wr_strobe, e_strobe);
    check(sector_wr_ok == e_ok, "R9 sector_wr_ok", sector_wr_ok, e_ok);
    check(force_read == e_force, "R6 force_read", force_read, e_force);
    if (wr_strobe) strobes++;
    if (sector_wr_ok) oks++;
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse(input logic [3:0] sec, input int len);
    sector_addr = sec; ce_n = 0; we_n = 0;
    idle(len);
    ce_n = 1; we_n = 1;
    idle(2);
  endtask

  task automatic expect_counts(input string req, input int es, input int eo);
    check(strobes == es, req, strobes, es);
    check(oks == eo, req, oks, eo);
    strobes = 0; oks = 0;
  endtask

  task automatic cmd(input bit lk, input bit ul, input logic [3:0] sec);
    lock_sector = sec; lock_req = lk; unlock_req = ul;
    idle(1);
    lock_req = 0; unlock_req = 0;
  endtask

  initial begin
    #1;
    check(wr_strobe == 0 && sector_wr_ok == 0 && force_read == 0, "R8 reset outputs",
          {wr_strobe, sector_wr_ok, force_read}, 0);
    idle(3); rst_n = 1; idle(2);

    pulse(4'd5, MP);       expect_counts("R2 exact width", 1, 1);
    pulse(4'd5, MP-1);     expect_counts("R2 short pulse", 0, 0);
    pulse(4'd6, 10);       expect_counts("R2 long pulse one strobe", 1, 1);
    oe_n = 0; pulse(4'd5, 6); oe_n = 1; expect_counts("R1 oe low blocks", 0, 0);
    sector_addr = 4'd5; ce_n = 0; idle(6); ce_n = 1; idle(2); expect_counts("R1 we high blocks", 0, 0);
    we_n = 0; idle(6); we_n = 1; idle(2); expect_counts("R1 ce high blocks", 0, 0);
    ce_n = 0; we_n = 1; idle(1); we_n = 0; idle(1); we_n = 1; idle(1); we_n = 0; idle(1);
    ce_n = 1; we_n = 1; idle(2); expect_counts("R2 glitches", 0, 0);

    cmd(1, 0, 4'd5); pulse(4'd5, MP); expect_counts("R5 locked", 1, 0);
    pulse(4'd7, MP);       expect_counts("R5 other sector", 1, 1);
    cmd(0, 1, 4'd5); pulse(4'd5, MP); expect_counts("R5 unlocked", 1, 1);
    cmd(1, 1, 4'd9); pulse(4'd9, MP); expect_counts("R5 lock wins", 1, 0);
    cmd(0, 1, 4'd9);

    wp_n = 0;
    pulse(4'd0, MP);       expect_counts("R3 sector 0", 1, 0);
    pulse(4'd15, MP);      expect_counts("R3 last sector", 1, 0);
    pulse(4'd8, MP);       expect_counts("R3 middle ok", 1, 1);
    wp_n = 1;
    pulse(4'd0, MP);       expect_counts("R3 released", 1, 1);

    vpp_hi = 0;
    pulse(4'd8, MP);       expect_counts("R4 vpp low", 1, 0);
    vpp_hi = 1;

    supply_low = 1;
    pulse(4'd3, 6);        expect_counts("R6 supply low", 0, 0);
    cmd(1, 0, 4'd3);
    supply_low = 0; idle(1);
    check(force_read == 0, "R6 force_read release", force_read, 0);
    pulse(4'd3, MP);       expect_counts("R7 write after release", 1, 1);

    supply_low = 1; sector_addr = 4'd4; ce_n = 0; we_n = 0; idle(2);
    supply_low = 0; idle(MP-1);
    check(strobes == 0, "R7 fresh run needed", strobes, 0);
    idle(1); ce_n = 1; we_n = 1; idle(2);
    expect_counts("R7 fresh run", 1, 1);

    rst_n = 0; #1;
    check(wr_strobe == 0 && sector_wr_ok == 0 && force_read == 0, "R8 reset again",
          {wr_strobe, sector_wr_ok, force_read}, 0);
    idle(2); rst_n = 1; idle(1);
    pulse(4'd9, MP);       expect_counts("R8 locks cleared", 1, 1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #100000;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule